// File: doc/BRIEF.md
# External Trigger Conditioner

This block turns an asynchronous trigger pin into a clean trigger for a command queue. First the raw pin passes through a two-flop synchroniser. A programmable glitch filter then requires the synchronised level to hold steady for a set number of clocks before it accepts a change. A detector then reports the selected trigger condition. In the two edge modes it produces a single-cycle event. In the two level modes it produces a gate that stays asserted while the filtered signal sits at the chosen level.

The filter length, the mode and the enable are static configuration inputs. While the block is disabled, every output reads inactive. During that time the filter follows the synchronised pin, so that re-enabling the block neither replays a stale transition nor waits out a filter window. Queue control and arbitration lie outside this block.

Top module: `trig_cond`

## Requirements
- R1: `trig_mode` selects the condition: 2'b00 rising edge, 2'b01 falling edge, 2'b10 high level, 2'b11 low level. `edge_evt` is asserted only in the two edge modes, and `level_act` only in the two level modes.
- R2: The raw pin is synchronised by two flops. With `filt_len` = 0, a change on `trig_raw` that is set up before clock edge k shows on `trig_filt` just after edge k+2.
- R3: `trig_filt` takes a new value only after the synchronised input has held that value for `filt_len`+1 consecutive clocks. A change that is set up before edge k therefore shows just after edge k+2+`filt_len`.
- R4: A pulse on `trig_raw` shorter than `filt_len`+1 clocks leaves `trig_filt` unchanged. A run that is interrupted restarts the count from zero.
- R5: In rising mode, each filtered 0-to-1 transition gives exactly one single-cycle `edge_evt`, in the first cycle that `trig_filt` reads 1.
- R6: In falling mode, each filtered 1-to-0 transition gives exactly one single-cycle `edge_evt`, in the first cycle that `trig_filt` reads 0.
- R7: In high-level mode, `level_act` is 1 in exactly the cycles in which the filtered signal is 1.
- R8: In low-level mode, `level_act` is 1 in exactly the cycles in which the filtered signal is 0.
- R9: While `trig_en` is 0, `trig_filt`, `edge_evt` and `level_act` are all 0, and the filter state follows the synchronised input. On re-enable, `trig_filt` shows the current level in the first enabled cycle, and no `edge_evt` arises from anything that changed while the block was disabled.
- R10: After reset, the filter state and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_raw | input | 1 | Asynchronous trigger pin |
| trig_mode | input | 2 | Trigger condition select (see R1) |
| filt_len | input | LEN_W (4) | Filter setting N; 0 disables filtering |
| trig_en | input | 1 | Conditioner enable |
| trig_filt | output | 1 | Filtered trigger level, gated by enable |
| edge_evt | output | 1 | Single-cycle edge event |
| level_act | output | 1 | Level-qualified gate |

## Verification
The hardest situation to reach from the ports is a run of the new level that comes within one clock of qualifying and is then broken. The filter must throw away its partial count rather than carry it over. The stimulus drives pin patterns cycle by cycle at the falling clock edge. It includes pulses exactly N and N+1 clocks wide across several filter lengths, and a three-clock run broken by one low cycle ahead of a qualifying run. Re-enabling after a change made while disabled is covered in both edge and level modes, so that any leftover history in the detector would show up as a spurious event.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

  typedef enum logic [1:0] {
    TRG_RISE = 2'b00,
    TRG_FALL = 2'b01,
    TRG_HIGH = 2'b10,
    TRG_LOW  = 2'b11
  } trg_mode_e;

  // level modes carry bit 1 set
  function automatic logic mode_is_level(input logic [1:0] m);
    return m[1];
  endfunction

  // a run has qualified once its count reaches the programmed length
  function automatic logic run_qualified(input logic [7:0] cnt, input logic [7:0] len);
    return cnt >= len;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trig_filter.sv
module trig_filter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  input  logic [LEN_W-1:0] len,
  output logic             filt_q,
  output logic             accept_w
);
  import trig_cond_pkg::*;

  logic [LEN_W-1:0] run_cnt;
  logic             differs_w;

  assign differs_w = (din != filt_q);
  assign accept_w  = en && differs_w &&
                     run_qualified(8'(run_cnt), 8'(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q  <= 1'b0;
      run_cnt <= '0;
    end else if (!en) begin
      filt_q  <= din;
      run_cnt <= '0;
    end else if (!differs_w) begin
      run_cnt <= '0;
    end else if (accept_w) begin
      filt_q  <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R3: an enabled change of filtered state needs a completed run
  assert_filt_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (filt_q != $past(filt_q))) |->
      ($past(run_cnt) >= $past(len) && filt_q == $past(din)));
endmodule

// File: rtl/trig_detect.sv
module trig_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       filt,
  output logic       edge_evt,
  output logic       level_act
);
  import trig_cond_pkg::*;

  logic prev_q, en_q;
  logic rise_w, fall_w, hi_w, lo_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= filt;
      en_q   <= en;
    end
  end

  assign rise_w = en && en_q && filt && !prev_q;
  assign fall_w = en && en_q && !filt && prev_q;
  assign hi_w   = en && filt;
  assign lo_w   = en && !filt;

  always_comb begin
    edge_evt  = 1'b0;
    level_act = 1'b0;
    unique case (trg_mode_e'(mode))
      TRG_RISE: edge_evt  = rise_w;
      TRG_FALL: edge_evt  = fall_w;
      TRG_HIGH: level_act = hi_w;
      TRG_LOW:  level_act = lo_w;
      default:  ;
    endcase
  end

  // R5 / R6: edge events never span two cycles
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !edge_evt);

  // R1: output kind matches mode class
  assert_edge_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> !mode_is_level(mode));
  assert_level_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level_act |-> mode_is_level(mode));
endmodule

// File: rtl/trig_cond.sv
module trig_cond #(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_raw,
  input  logic [1:0]       trig_mode,
  input  logic [LEN_W-1:0] filt_len,
  input  logic             trig_en,
  output logic             trig_filt,
  output logic             edge_evt,
  output logic             level_act
);
  logic sync_w, filt_w, accept_w;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_raw), .dout(sync_w));

  trig_filter #(.LEN_W(LEN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(trig_en), .din(sync_w),
    .len(filt_len), .filt_q(filt_w), .accept_w(accept_w));

  trig_detect u_det (
    .clk(clk), .rst_n(rst_n), .en(trig_en), .mode(trig_mode),
    .filt(filt_w), .edge_evt(edge_evt), .level_act(level_act));

  assign trig_filt = trig_en && filt_w;

  // R9: disabled block is silent
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |-> (!trig_filt && !edge_evt && !level_act));

  // R9: the first enabled cycle never carries an edge event
  assert_wake_no_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!trig_en) && trig_en) |-> !edge_evt);

  // R3: an accepted run always flips the filtered level at the next edge
  assert_accept_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (filt_w != $past(filt_w)));
endmodule

// File: tb/trig_cond_tb.sv
module trig_cond_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_raw = 1'b0;
  logic [1:0] trig_mode = 2'b00;
  logic [3:0] filt_len = 4'd0;
  logic       trig_en = 1'b1;
  logic       trig_filt, edge_evt, level_act;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  trig_cond u_dut (
    .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .trig_mode(trig_mode),
    .filt_len(filt_len), .trig_en(trig_en), .trig_filt(trig_filt),
    .edge_evt(edge_evt), .level_act(level_act));

  localparam int WIN = 60;
  localparam int NVEC = 14;
  // {mode[1:0], N[3:0], pulse width[5:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 4'd0,  6'd1},  {2'd0, 4'd0,  6'd3},  {2'd0, 4'd3,  6'd3},
    {2'd0, 4'd3,  6'd4},  {2'd1, 4'd2,  6'd5},  {2'd1, 4'd5,  6'd5},
    {2'd1, 4'd5,  6'd6},  {2'd2, 4'd1,  6'd7},  {2'd2, 4'd7,  6'd7},
    {2'd2, 4'd7,  6'd8},  {2'd3, 4'd4,  6'd9},  {2'd3, 4'd15, 6'd16},
    {2'd3, 4'd15, 6'd15}, {2'd0, 4'd15, 6'd20}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int vm, input int vn, input int vw);
    int  rise_at = -1;
    int  edge_at = -1;
    int  edge_n  = 0;
    int  lvl_n   = 0;
    bit  pass    = (vw >= vn + 1);
    int  exp_edge_at;
    int  exp_lvl;
    trig_mode = 2'(vm);
    filt_len  = 4'(vn);
    trig_raw  = 1'b0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (trig_filt && rise_at < 0) rise_at = i;
      if (edge_evt) begin
        edge_n++;
        if (edge_at < 0) edge_at = i;
      end
      if (level_act) lvl_n++;
      trig_raw = (i < vw);
    end
    // R3/R4: filtered rise latency N+3 or rejection
    check($sformatf("R3/R4 rise index m%0d n%0d w%0d", vm, vn, vw),
          rise_at, pass ? vn + 3 : -1);
    // R1/R5/R6: event count and position
    exp_edge_at = -1;
    if (pass && vm == 0) exp_edge_at = vn + 3;
    if (pass && vm == 1) exp_edge_at = vw + vn + 3;
    check($sformatf("R5/R6 event count m%0d n%0d w%0d", vm, vn, vw),
          edge_n, (exp_edge_at >= 0) ? 1 : 0);
    check($sformatf("R5/R6 event index m%0d n%0d w%0d", vm, vn, vw),
          edge_at, exp_edge_at);
    // R1/R7/R8: level gate cycles
    exp_lvl = 0;
    if (vm == 2) exp_lvl = pass ? vw : 0;
    if (vm == 3) exp_lvl = pass ? WIN - vw : WIN;
    check($sformatf("R7/R8 level cycles m%0d n%0d w%0d", vm, vn, vw),
          lvl_n, exp_lvl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rise_at;
    int cnt;
    // R10: reset state
    trig_mode = 2'b10;
    repeat (3) @(negedge clk);
    check("R10 trig_filt in reset", int'(trig_filt), 0);
    check("R10 level_act in reset", int'(level_act), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 trig_filt after reset", int'(trig_filt), 0);
    check("R10 edge_evt after reset", int'(edge_evt), 0);

    // R2: zero-length filter latency of 3 edges
    trig_mode = 2'b00;
    filt_len = 4'd0;
    repeat (5) @(negedge clk);
    trig_raw = 1'b1;
    rise_at = -1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (trig_filt && rise_at < 0) rise_at = i;
    end
    check("R2 sync latency", rise_at, 3);
    trig_raw = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_vec(int'(VEC[v][11:10]), int'(VEC[v][9:6]), int'(VEC[v][5:0]));

    // R4: interrupted run restarts count (N=3)
    trig_mode = 2'b10;
    filt_len = 4'd3;
    trig_raw = 1'b0;
    repeat (30) @(negedge clk);
    rise_at = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (trig_filt && rise_at < 0) rise_at = i;
      trig_raw = (i < 3) || (i >= 4 && i < 8);
    end
    check("R4 interrupted run restart", rise_at, 10);

    // R9: disabled outputs quiet while pin is high, filter tracks
    trig_mode = 2'b00;
    filt_len = 4'd9;
    trig_raw = 1'b0;
    repeat (30) @(negedge clk);
    trig_en = 1'b0;
    trig_raw = 1'b1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (trig_filt || edge_evt || level_act) cnt++;
    end
    check("R9 quiet while disabled", cnt, 0);
    trig_en = 1'b1;
    @(negedge clk);
    check("R9 filtered level on wake", int'(trig_filt), 1);
    cnt = 0;
    for (int i = 0; i < 15; i++) begin
      if (edge_evt) cnt++;
      @(negedge clk);
    end
    check("R9 no event after wake", cnt, 0);

    // R9: quick toggle right before wake, falling mode
    trig_mode = 2'b01;
    trig_en = 1'b0;
    trig_raw = 1'b0;
    repeat (2) @(negedge clk);
    trig_en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      if (edge_evt) cnt++;
      @(negedge clk);
    end
    check("R9 no event from disabled fall", cnt, 0);

    // R9: low mode gated off while disabled
    trig_mode = 2'b11;
    trig_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 low mode gate off when disabled", int'(level_act), 0);
    trig_en = 1'b1;
    @(negedge clk);
    check("R8 low mode gate on wake", int'(level_act), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule